// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits between two independent access ports and a shared two-port word array. Each cycle it compares the two ports' requests. When both ports are enabled on the same word it grants the word to one port. It drives an active-low busy flag toward the other port and suppresses that port's write strobe so the contested word cannot be corrupted. The port that was already sitting on the word wins. If both arrive in the same cycle, the left port wins.

A mode input picks the block's role. In master mode the block arbitrates and publishes its decision on the busy outputs, which another copy of the block can consume. In slave mode the block stops arbitrating. Its busy outputs then repeat busy inputs taken from a master, and those inputs gate its writes, so several copies can be stacked into a wider word and all obey one decision.

Top module: `dp_collision_arbiter`

## Requirements
- R1: While rst_ni is low and in the first cycle after it, with no collision pending, both busy outputs are 1 (released).
- R2: A collision exists only when l_en_i and r_en_i are both 1 and l_addr_i equals r_addr_i. Different addresses, or either enable low, never assert busy and never block a write.
- R3: In master mode, a port counts as settled when it held its enable and the same address in the previous cycle. If exactly one port is settled when a collision starts, that port wins and the other port's busy output goes to 0.
- R4: In master mode, if a collision starts with both ports settled or both new, the left port wins and r_busy_no goes to 0.
- R5: In master mode busy is registered. It asserts on the first clock edge after the collision is seen, and it releases on the first clock edge after the collision ends, whether the addresses differ or an enable drops.
- R6: The winner keeps the word for as long as the collision continues without a break. This holds even if both ports move together to a new shared address.
- R7: In master mode the loser's write output is 0 in every cycle of a collision, including the first. The winner's write output follows its request (l_wr_o = l_en_i & l_wr_i when not losing).
- R8: In slave mode no arbitration is done. Each busy output equals its busy input in the same cycle, and a port's write output is en & wr & its busy input, even during a collision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 = master (arbitrate), 0 = slave (obey busy inputs) |
| l_en_i | input | 1 | Left port enable |
| l_wr_i | input | 1 | Left port write request |
| l_addr_i | input | ADDR_W | Left port word address |
| r_en_i | input | 1 | Right port enable |
| r_wr_i | input | 1 | Right port write request |
| r_addr_i | input | ADDR_W | Right port word address |
| l_busy_ni | input | 1 | Busy from master toward left port, active low (slave mode) |
| r_busy_ni | input | 1 | Busy from master toward right port, active low (slave mode) |
| l_busy_no | output | 1 | Busy toward left port, active low |
| r_busy_no | output | 1 | Busy toward right port, active low |
| l_wr_o | output | 1 | Gated write strobe of left port to the array |
| r_wr_o | output | 1 | Gated write strobe of right port to the array |

## Verification
The write outputs and the slave-mode busy outputs are combinational, so they are due in the same cycle as the inputs that cause them. The master-mode busy outputs are due one clock edge after a collision starts or ends. The bench drives inputs just after the falling edge and samples all four outputs shortly after that, before the next rising edge. Its model advances its owner and arrival history only at the rising edge, so registered busy is compared one cycle after its cause and the write gate in the cycle of the cause.

// File: rtl/dp_arb_pkg.sv
`timescale 1ns/1ps
package dp_arb_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  localparam int unsigned NUM_PORTS = 2;
  localparam int unsigned PORT_L    = 0;
  localparam int unsigned PORT_R    = 1;
endpackage

// File: rtl/arrival_track.sv
`timescale 1ns/1ps
// Flags a port that held the same enabled address on the previous edge.
module arrival_track #(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              settled_o
);
  logic              en_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      en_q   <= en_i;
      addr_q <= addr_i;
    end
  end

  assign settled_o = en_i && en_q && (addr_q == addr_i);
endmodule

// File: rtl/owner_arb.sv
`timescale 1ns/1ps
module owner_arb
  import dp_arb_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   master_i,
  input  logic   match_i,
  input  logic   l_settled_i,
  input  logic   r_settled_i,
  output owner_e owner_q_o,
  output owner_e win_o
);
  owner_e owner_q;

  // Held owner wins while the collision persists; otherwise earlier arrival, ties to left.
  always_comb begin
    if (!match_i)                       win_o = OWN_NONE;
    else if (owner_q != OWN_NONE)       win_o = owner_q;
    else if (r_settled_i && !l_settled_i) win_o = OWN_RIGHT;
    else                                win_o = OWN_LEFT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       owner_q <= OWN_NONE;
    else if (master_i) owner_q <= win_o;
    else               owner_q <= OWN_NONE;
  end

  assign owner_q_o = owner_q;
endmodule

// File: rtl/port_gate.sv
`timescale 1ns/1ps
module port_gate (
  input  logic master_i,
  input  logic en_i,
  input  logic wr_i,
  input  logic lose_now_i,
  input  logic busy_own_ni,
  input  logic busy_in_ni,
  output logic busy_no,
  output logic wr_o
);
  logic allow;

  assign allow   = master_i ? !lose_now_i : busy_in_ni;
  assign wr_o    = en_i && wr_i && allow;
  assign busy_no = master_i ? busy_own_ni : busy_in_ni;
endmodule

// File: rtl/dp_collision_arbiter.sv
`timescale 1ns/1ps
module dp_collision_arbiter
  import dp_arb_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              l_en_i,
  input  logic              l_wr_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic              r_en_i,
  input  logic              r_wr_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic              l_busy_ni,
  input  logic              r_busy_ni,
  output logic              l_busy_no,
  output logic              r_busy_no,
  output logic              l_wr_o,
  output logic              r_wr_o
);
  logic [NUM_PORTS-1:0]             en, wr, settled, lose_now, busy_own_n, busy_in_n, busy_out_n, wr_out;
  logic [NUM_PORTS-1:0][ADDR_W-1:0] addr;
  logic                             match;
  owner_e                           owner_q, win;

  assign en[PORT_L]        = l_en_i;
  assign en[PORT_R]        = r_en_i;
  assign wr[PORT_L]        = l_wr_i;
  assign wr[PORT_R]        = r_wr_i;
  assign addr[PORT_L]      = l_addr_i;
  assign addr[PORT_R]      = r_addr_i;
  assign busy_in_n[PORT_L] = l_busy_ni;
  assign busy_in_n[PORT_R] = r_busy_ni;

  assign match = en[PORT_L] && en[PORT_R] && (addr[PORT_L] == addr[PORT_R]);

  // A port loses / is busied when the other side owns the word.
  assign lose_now[PORT_L]   = (win == OWN_RIGHT);
  assign lose_now[PORT_R]   = (win == OWN_LEFT);
  assign busy_own_n[PORT_L] = (owner_q != OWN_RIGHT);
  assign busy_own_n[PORT_R] = (owner_q != OWN_LEFT);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    arrival_track #(.ADDR_W(ADDR_W)) u_track (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en[p]),
      .addr_i    (addr[p]),
      .settled_o (settled[p])
    );

    port_gate u_gate (
      .master_i    (master_i),
      .en_i        (en[p]),
      .wr_i        (wr[p]),
      .lose_now_i  (lose_now[p]),
      .busy_own_ni (busy_own_n[p]),
      .busy_in_ni  (busy_in_n[p]),
      .busy_no     (busy_out_n[p]),
      .wr_o        (wr_out[p])
    );
  end

  owner_arb u_owner (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .master_i    (master_i),
    .match_i     (match),
    .l_settled_i (settled[PORT_L]),
    .r_settled_i (settled[PORT_R]),
    .owner_q_o   (owner_q),
    .win_o       (win)
  );

  assign l_busy_no = busy_out_n[PORT_L];
  assign r_busy_no = busy_out_n[PORT_R];
  assign l_wr_o    = wr_out[PORT_L];
  assign r_wr_o    = wr_out[PORT_R];
endmodule

// File: rtl/dp_collision_arbiter_chk.sv
`timescale 1ns/1ps
module dp_collision_arbiter_chk #(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              master_i,
  input logic              l_en_i,
  input logic [ADDR_W-1:0] l_addr_i,
  input logic              r_en_i,
  input logic [ADDR_W-1:0] r_addr_i,
  input logic              l_busy_ni,
  input logic              r_busy_ni,
  input logic              l_busy_no,
  input logic              r_busy_no,
  input logic              l_wr_o,
  input logic              r_wr_o
);
  logic hit;
  assign hit = l_en_i && r_en_i && (l_addr_i == r_addr_i);

  // R3
  one_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i |-> (l_busy_no || r_busy_no));

  // R5
  release_after_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && $past(master_i) && !$past(hit)) |-> (l_busy_no && r_busy_no));

  // R6
  left_busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && $past(master_i) && $past(hit) && hit && !$past(l_busy_no)) |-> !l_busy_no);

  // R6
  right_busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && $past(master_i) && $past(hit) && hit && !$past(r_busy_no)) |-> !r_busy_no);

  // R7
  busied_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && hit) |-> ((l_busy_no || !l_wr_o) && (r_busy_no || !r_wr_o)));

  // R8
  slave_mirror_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> (l_busy_no == l_busy_ni && r_busy_no == r_busy_ni));

  // R8
  slave_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> ((l_busy_ni || !l_wr_o) && (r_busy_ni || !r_wr_o)));
endmodule

bind dp_collision_arbiter dp_collision_arbiter_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_dp_collision_arbiter.sv
`timescale 1ns/1ps
module tb_dp_collision_arbiter;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned MAX_CYC = 200000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic master_i = 1'b1;
  logic l_en_i = 1'b0, l_wr_i = 1'b0, r_en_i = 1'b0, r_wr_i = 1'b0;
  logic [ADDR_W-1:0] l_addr_i = '0, r_addr_i = '0;
  logic l_busy_ni = 1'b1, r_busy_ni = 1'b1;
  logic l_busy_no, r_busy_no, l_wr_o, r_wr_o;

  int errors = 0;
  int checks = 0;

  // reference state: 0 none, 1 left, 2 right
  int          owner_m = 0;
  bit          l_seen = 0, r_seen = 0;
  int unsigned l_prev = 0, r_prev = 0;

  always #4 clk = ~clk;

  dp_collision_arbiter #(.ADDR_W(ADDR_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .master_i(master_i),
    .l_en_i(l_en_i), .l_wr_i(l_wr_i), .l_addr_i(l_addr_i),
    .r_en_i(r_en_i), .r_wr_i(r_wr_i), .r_addr_i(r_addr_i),
    .l_busy_ni(l_busy_ni), .r_busy_ni(r_busy_ni),
    .l_busy_no(l_busy_no), .r_busy_no(r_busy_no),
    .l_wr_o(l_wr_o), .r_wr_o(r_wr_o)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input logic m, input logic le, input logic lw, input int unsigned la,
                      input logic re, input logic rw, input int unsigned ra,
                      input logic lbi, input logic rbi, input string req);
    bit coll, l_set, r_set;
    int win;
    logic e_lb, e_rb, e_lw, e_rw;
    @(negedge clk);
    master_i = m; l_en_i = le; l_wr_i = lw; l_addr_i = la[ADDR_W-1:0];
    r_en_i = re; r_wr_i = rw; r_addr_i = ra[ADDR_W-1:0]; l_busy_ni = lbi; r_busy_ni = rbi;
    #1;
    coll  = le && re && (la == ra);
    l_set = le && l_seen && (la == l_prev);
    r_set = re && r_seen && (ra == r_prev);
    if (!coll) win = 0;
    else if (owner_m != 0) win = owner_m;
    else if (r_set && !l_set) win = 2;
    else win = 1;
    if (m) begin
      e_lb = (owner_m != 2);
      e_rb = (owner_m != 1);
      e_lw = le && lw && (win != 2);
      e_rw = re && rw && (win != 1);
    end else begin
      e_lb = lbi;
      e_rb = rbi;
      e_lw = le && lw && lbi;
      e_rw = re && rw && rbi;
    end
    chk(req, "l_busy_no", l_busy_no, e_lb);
    chk(req, "r_busy_no", r_busy_no, e_rb);
    chk(req, "l_wr_o", l_wr_o, e_lw);
    chk(req, "r_wr_o", r_wr_o, e_rw);
    @(posedge clk);
    owner_m = m ? win : 0;
    l_seen = le; l_prev = la;
    r_seen = re; r_prev = ra;
  endtask

  initial begin : watchdog
    repeat (MAX_CYC) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    repeat (2) @(negedge clk);
    #1;
    chk("R1", "l_busy_no in reset", l_busy_no, 1'b1);
    chk("R1", "r_busy_no in reset", r_busy_no, 1'b1);
    @(negedge clk);
    rst_ni = 1'b1;
    step(1, 0,0,0, 0,0,0, 1,1, "R1");

    // R2: different words, single enable on same word
    step(1, 1,1,5, 1,1,6, 1,1, "R2");
    step(1, 1,1,5, 1,1,6, 1,1, "R2");
    step(1, 1,1,7, 0,1,7, 1,1, "R2");
    step(1, 0,1,7, 1,1,7, 1,1, "R2");
    step(1, 0,0,0, 0,0,0, 1,1, "R2");

    // R3 left first, R7 right write blocked, R6 hold, R5 release on enable drop
    step(1, 1,0,10, 0,0,0, 1,1, "R3");
    step(1, 1,1,10, 1,1,10, 1,1, "R7");
    step(1, 1,1,10, 1,1,10, 1,1, "R3");
    step(1, 1,0,10, 1,1,10, 1,1, "R6");
    step(1, 1,1,10, 0,1,10, 1,1, "R5");
    step(1, 1,1,10, 0,0,0, 1,1, "R5");

    // R3 right first, R5 release on address mismatch
    step(1, 0,0,0, 1,1,20, 1,1, "R3");
    step(1, 1,1,20, 1,1,20, 1,1, "R7");
    step(1, 1,1,20, 1,0,20, 1,1, "R3");
    step(1, 1,1,21, 1,1,20, 1,1, "R5");
    step(1, 1,1,21, 1,1,20, 1,1, "R5");
    step(1, 0,0,0, 0,0,0, 1,1, "R5");

    // R4 same-cycle arrival, both writing
    step(1, 1,1,30, 1,1,30, 1,1, "R4");
    step(1, 1,1,30, 1,1,30, 1,1, "R4");
    step(1, 0,0,0, 0,0,0, 1,1, "R4");
    step(1, 0,0,0, 0,0,0, 1,1, "R4");

    // R6 right owner kept while both move to a new shared word
    step(1, 0,0,0, 1,0,40, 1,1, "R6");
    step(1, 1,1,40, 1,1,40, 1,1, "R6");
    step(1, 1,1,41, 1,1,41, 1,1, "R6");
    step(1, 1,1,41, 1,1,41, 1,1, "R6");
    step(1, 1,1,0, 1,1,0, 1,1, "R6");
    step(1, 0,0,0, 0,0,0, 1,1, "R6");
    step(1, 0,0,0, 0,0,0, 1,1, "R6");

    // R8 slave mode: busy follows inputs, writes gated by them
    step(0, 1,1,50, 1,1,50, 0,1, "R8");
    step(0, 1,1,50, 1,1,50, 0,1, "R8");
    step(0, 1,1,50, 1,1,50, 1,0, "R8");
    step(0, 1,1,50, 1,1,50, 1,1, "R8");
    step(0, 1,1,60, 0,0,0, 0,0, "R8");
    // back to master with an ongoing collision: both settled -> left
    step(0, 1,1,70, 1,1,70, 1,1, "R8");
    step(1, 1,1,70, 1,1,70, 1,1, "R4");
    step(1, 1,1,70, 1,1,70, 1,1, "R4");
    step(1, 0,0,0, 0,0,0, 1,1, "R5");
    step(1, 0,0,0, 0,0,0, 1,1, "R5");

    // R2 highest address and mismatch in top bit
    step(1, 1,1,4095, 1,1,2047, 1,1, "R2");
    step(1, 1,1,4095, 1,1,2047, 1,1, "R2");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule